// File: doc/BRIEF.md
# Coin-Operated Washer Cycle Controller

This block sequences one paid wash cycle for a coin-operated washing machine. A coin arms the machine. A start request with the door shut then runs five timed phases in fixed order: fill, heat, wash, rinse and spin. When spin ends, the machine goes back to idle and waits for the next coin. Each phase has its own duration parameter, and a down-counter is reloaded every time a phase is entered.

A cancel before the cycle begins refunds the coin. A cancel after the cycle has begun keeps the coin. A motor failure, an imbalance report, or a fill or heat phase that runs out of time passes through a one-clock fault state and returns the machine to the armed state, so the customer can resume without paying again. A sticky fault flag shows that such an event happened. The flag clears when the armed state is next left.

The control FSM and the phase timer are separate modules. The FSM drives the timer through a small strobe struct.

Top module: `washer_cycle_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle (state code 0) and drives every output low, including the fault flag and coin return.
- R2: In idle, a coin input moves the machine to armed (code 1) on the next clock. In idle, start and cancel have no effect.
- R3: A cancel in armed returns the machine to idle and raises coin return for exactly one cycle, the cycle that follows the cancel. Cancel takes priority over start.
- R4: In armed, start with the door closed moves the machine to fill (code 2). Start with the door open leaves it in armed.
- R5: Fill moves to heat (code 3) when the level-reached strobe arrives, and heat moves to wash (code 4) when the heat-reached strobe arrives. If the strobe is still absent after the phase has lasted its full parameter count of cycles, the machine goes to fault (code 7). A strobe in that last cycle still advances the phase.
- R6: Wash, rinse (code 5) and spin (code 6) each last exactly their parameter count of cycles, then move to the next phase. After spin the machine returns to idle.
- R7: A cancel in any phase from fill to spin returns the machine to idle on the next clock and does not raise coin return. Cancel takes priority over faults.
- R8: Motor failure or imbalance in any phase from fill to spin sends the machine to fault. Fault lasts exactly one cycle and is always followed by armed.
- R9: The fault flag goes high in the cycle the machine is in fault. It stays high through armed and drops on the first transition out of armed.
- R10: The water valve is high only in fill and rinse. The heater is high only in heat. The wash motor is high only in wash and rinse. The spin motor is high only in spin. The door lock is high in every phase from fill to spin.
- R11: The state code reports idle=0, armed=1, fill=2, heat=3, wash=4, rinse=5, spin=6 and fault=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coinIn | input | 1 | Coin accepted |
| startReq | input | 1 | Customer start request |
| cancelReq | input | 1 | Customer cancel request |
| doorClosed | input | 1 | Door sensor, high when shut |
| motorFail | input | 1 | Motor failure report |
| outOfBalance | input | 1 | Drum imbalance report |
| levelDone | input | 1 | Water level reached strobe |
| heatDone | input | 1 | Temperature reached strobe |
| coinReturn | output | 1 | One-cycle refund pulse |
| waterValve | output | 1 | Water inlet valve enable |
| heaterOn | output | 1 | Heater enable |
| motorWash | output | 1 | Agitation motor enable |
| motorSpin | output | 1 | Spin motor enable |
| doorLock | output | 1 | Door lock |
| faultFlag | output | 1 | Sticky fault indication |
| stateCode | output | 3 | Current state code |

## Verification
The bench builds the block with short phase lengths: fill 6, heat 5, wash 8, rinse 7 and spin 9 cycles. At these lengths a complete cycle, a fill timeout and a fault inside any phase all fit into a few dozen clocks. Random stimulus with low fault and cancel rates then reaches spin completion many times, alongside frequent cancels and faults in every phase. The last-cycle races, where a sensor strobe or a fault arrives on the same clock as the timer expiry, come up often within a few thousand cycles.

// File: rtl/washer_pkg.sv
package washer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_FILL  = 3'd2,
    ST_HEAT  = 3'd3,
    ST_WASH  = 3'd4,
    ST_RINSE = 3'd5,
    ST_SPIN  = 3'd6,
    ST_FAULT = 3'd7
  } washState_e;

  // Strobes from control to the phase timer
  typedef struct packed {
    logic       loadTimer;
    washState_e loadPhase;
  } timerCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/washer_phase_timer.sv
module washer_phase_timer
  import washer_pkg::*;
#(
  parameter int FILL_CYC  = 200,
  parameter int HEAT_CYC  = 150,
  parameter int WASH_CYC  = 600,
  parameter int RINSE_CYC = 400,
  parameter int SPIN_CYC  = 300
) (
  input  logic      clk,
  input  logic      rst,
  input  timerCtl_t ctl,
  output logic      timerDone
);

  localparam int MAX_CYC = maxOf(maxOf(maxOf(FILL_CYC, HEAT_CYC), maxOf(WASH_CYC, RINSE_CYC)), SPIN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;

  // Phase lasting N cycles loads N-1; done while the count is zero
  always_comb begin
    case (ctl.loadPhase)
      ST_FILL:  loadVal = CNT_W'(FILL_CYC - 1);
      ST_HEAT:  loadVal = CNT_W'(HEAT_CYC - 1);
      ST_WASH:  loadVal = CNT_W'(WASH_CYC - 1);
      ST_RINSE: loadVal = CNT_W'(RINSE_CYC - 1);
      ST_SPIN:  loadVal = CNT_W'(SPIN_CYC - 1);
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (ctl.loadTimer) count <= loadVal;
    else if (count != '0)   count <= count - CNT_W'(1);
  end

  assign timerDone = (count == '0);

  assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadTimer && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadTimer && timerDone) |=> timerDone);

endmodule

// File: rtl/washer_seq_fsm.sv
module washer_seq_fsm
  import washer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      coinIn,
  input  logic      startReq,
  input  logic      cancelReq,
  input  logic      doorClosed,
  input  logic      motorFail,
  input  logic      outOfBalance,
  input  logic      levelDone,
  input  logic      heatDone,
  input  logic      timerDone,
  output timerCtl_t ctl,
  output logic      coinReturn,
  output logic      waterValve,
  output logic      heaterOn,
  output logic      motorWash,
  output logic      motorSpin,
  output logic      doorLock,
  output logic      faultFlag,
  output logic [2:0] stateCode
);

  washState_e state, nextState;
  logic activePhase;

  assign activePhase = (state inside {ST_FILL, ST_HEAT, ST_WASH, ST_RINSE, ST_SPIN});

  always_comb begin
    nextState = state;
    if (activePhase && cancelReq)                        nextState = ST_IDLE;
    else if (activePhase && (motorFail || outOfBalance)) nextState = ST_FAULT;
    else begin
      case (state)
        ST_IDLE:  if (coinIn) nextState = ST_ARMED;
        ST_ARMED: if (cancelReq) nextState = ST_IDLE;
                  else if (startReq && doorClosed) nextState = ST_FILL;
        ST_FILL:  if (levelDone) nextState = ST_HEAT;
                  else if (timerDone) nextState = ST_FAULT;
        ST_HEAT:  if (heatDone) nextState = ST_WASH;
                  else if (timerDone) nextState = ST_FAULT;
        ST_WASH:  if (timerDone) nextState = ST_RINSE;
        ST_RINSE: if (timerDone) nextState = ST_SPIN;
        ST_SPIN:  if (timerDone) nextState = ST_IDLE;
        default:  nextState = ST_ARMED;
      endcase
    end
  end

  assign ctl.loadTimer = (nextState != state);
  assign ctl.loadPhase = nextState;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      coinReturn <= 1'b0;
      faultFlag  <= 1'b0;
    end else begin
      state      <= nextState;
      coinReturn <= (state == ST_ARMED) && cancelReq;
      if (nextState == ST_FAULT)
        faultFlag <= 1'b1;
      else if (state == ST_ARMED && nextState != ST_ARMED)
        faultFlag <= 1'b0;
    end
  end

  assign waterValve = (state == ST_FILL) || (state == ST_RINSE);
  assign heaterOn   = (state == ST_HEAT);
  assign motorWash  = (state == ST_WASH) || (state == ST_RINSE);
  assign motorSpin  = (state == ST_SPIN);
  assign doorLock   = activePhase;
  assign stateCode  = state;

  assert_coin_arms_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && coinIn) |=> (state == ST_ARMED));

  assert_refund_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    coinReturn |=> !coinReturn);

  assert_refund_origin_R3: assert property (@(posedge clk) disable iff (rst)
    coinReturn |-> ($past(state) == ST_ARMED && state == ST_IDLE));

  assert_forfeit_R7: assert property (@(posedge clk) disable iff (rst)
    (activePhase && cancelReq) |=> (state == ST_IDLE && !coinReturn));

  assert_fault_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT) |=> (state == ST_ARMED));

  assert_flag_in_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT) |-> faultFlag);

  assert_spin_end_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SPIN && timerDone && !cancelReq && !motorFail && !outOfBalance)
      |=> (state == ST_IDLE));

endmodule

// File: rtl/washer_cycle_ctrl.sv
module washer_cycle_ctrl
  import washer_pkg::*;
#(
  parameter int FILL_CYC  = 200,
  parameter int HEAT_CYC  = 150,
  parameter int WASH_CYC  = 600,
  parameter int RINSE_CYC = 400,
  parameter int SPIN_CYC  = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coinIn,
  input  logic       startReq,
  input  logic       cancelReq,
  input  logic       doorClosed,
  input  logic       motorFail,
  input  logic       outOfBalance,
  input  logic       levelDone,
  input  logic       heatDone,
  output logic       coinReturn,
  output logic       waterValve,
  output logic       heaterOn,
  output logic       motorWash,
  output logic       motorSpin,
  output logic       doorLock,
  output logic       faultFlag,
  output logic [2:0] stateCode
);

  timerCtl_t timerCtl;
  logic      timerDone;

  washer_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .coinIn(coinIn), .startReq(startReq),
    .cancelReq(cancelReq), .doorClosed(doorClosed), .motorFail(motorFail),
    .outOfBalance(outOfBalance), .levelDone(levelDone), .heatDone(heatDone),
    .timerDone(timerDone), .ctl(timerCtl), .coinReturn(coinReturn),
    .waterValve(waterValve), .heaterOn(heaterOn), .motorWash(motorWash),
    .motorSpin(motorSpin), .doorLock(doorLock), .faultFlag(faultFlag),
    .stateCode(stateCode)
  );

  washer_phase_timer #(
    .FILL_CYC(FILL_CYC), .HEAT_CYC(HEAT_CYC), .WASH_CYC(WASH_CYC),
    .RINSE_CYC(RINSE_CYC), .SPIN_CYC(SPIN_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .ctl(timerCtl), .timerDone(timerDone)
  );

endmodule

// File: tb/tb_washer_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_washer_cycle_ctrl;

  localparam int FILL_T = 6, HEAT_T = 5, WASH_T = 8, RINSE_T = 7, SPIN_T = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, coinIn, startReq, cancelReq, doorClosed, motorFail, outOfBalance, levelDone, heatDone;
  logic coinReturn, waterValve, heaterOn, motorWash, motorSpin, doorLock, faultFlag;
  logic [2:0] stateCode;

  washer_cycle_ctrl #(.FILL_CYC(FILL_T), .HEAT_CYC(HEAT_T), .WASH_CYC(WASH_T),
                      .RINSE_CYC(RINSE_T), .SPIN_CYC(SPIN_T)) dut (
    .clk(clk), .rst(rst), .coinIn(coinIn), .startReq(startReq), .cancelReq(cancelReq),
    .doorClosed(doorClosed), .motorFail(motorFail), .outOfBalance(outOfBalance),
    .levelDone(levelDone), .heatDone(heatDone), .coinReturn(coinReturn),
    .waterValve(waterValve), .heaterOn(heaterOn), .motorWash(motorWash),
    .motorSpin(motorSpin), .doorLock(doorLock), .faultFlag(faultFlag), .stateCode(stateCode)
  );

  int errors = 0;
  int checks = 0;
  int mState = 0, mRem = 0;
  int mFlag = 0, mRet = 0;

  function automatic int durOf(input int s);
    case (s)
      2: return FILL_T;
      3: return HEAT_T;
      4: return WASH_T;
      5: return RINSE_T;
      6: return SPIN_T;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R11", "stateCode", int'(stateCode), mState);
    check("R3",  "coinReturn", int'(coinReturn), mRet);
    check("R10", "waterValve", int'(waterValve), int'(mState == 2 || mState == 5));
    check("R10", "heaterOn", int'(heaterOn), int'(mState == 3));
    check("R10", "motorWash", int'(motorWash), int'(mState == 4 || mState == 5));
    check("R10", "motorSpin", int'(motorSpin), int'(mState == 6));
    check("R10", "doorLock", int'(doorLock), int'(mState >= 2 && mState <= 6));
    check("R9",  "faultFlag", int'(faultFlag), mFlag);
  endtask

  task automatic modelStep();
    int n;
    n = mState;
    mRet = 0;
    if (mState >= 2 && mState <= 6) begin
      if (cancelReq) n = 0;
      else if (motorFail || outOfBalance) n = 7;
      else if (mState == 2) begin if (levelDone) n = 3; else if (mRem == 1) n = 7; end
      else if (mState == 3) begin if (heatDone) n = 4; else if (mRem == 1) n = 7; end
      else if (mRem == 1) n = (mState == 6) ? 0 : mState + 1;
    end else if (mState == 0) begin
      if (coinIn) n = 1;
    end else if (mState == 1) begin
      if (cancelReq) begin n = 0; mRet = 1; end
      else if (startReq && doorClosed) n = 2;
    end else n = 1;
    if (n == 7) mFlag = 1;
    else if (mState == 1 && n != 1) mFlag = 0;
    if (n != mState) mRem = durOf(n);
    else if (mRem > 1) mRem--;
    mState = n;
  endtask

  task automatic setIn(input logic c, input logic s, input logic x, input logic d,
                       input logic mf, input logic ob, input logic lv, input logic ht);
    coinIn = c; startReq = s; cancelReq = x; doorClosed = d;
    motorFail = mf; outOfBalance = ob; levelDone = lv; heatDone = ht;
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      setIn(0, 0, 0, 1, 0, 0, 0, 0);
      cycle();
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    setIn(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "stateCode", int'(stateCode), 0);
    check("R1", "outputs", int'({coinReturn, waterValve, heaterOn, motorWash, motorSpin, doorLock, faultFlag}), 0);

    // R2: start/cancel ignored in idle, coin arms
    setIn(0, 1, 1, 1, 0, 0, 0, 0); cycle();
    check("R2", "state after start/cancel in idle", int'(stateCode), 0);
    setIn(1, 0, 0, 1, 0, 0, 0, 0); cycle();
    check("R2", "state after coin", int'(stateCode), 1);

    // R4: door open blocks start; R3: cancel beats start and refunds
    setIn(0, 1, 0, 0, 0, 0, 0, 0); cycle();
    check("R4", "door open start", int'(stateCode), 1);
    setIn(0, 1, 1, 1, 0, 0, 0, 0); cycle();
    check("R3", "cancel in armed", int'(stateCode), 0);
    check("R3", "refund pulse", int'(coinReturn), 1);
    idleCycles(1);
    check("R3", "refund pulse width", int'(coinReturn), 0);

    // R5 fill timeout, R8/R9 fault path
    setIn(1, 0, 0, 1, 0, 0, 0, 0); cycle();
    setIn(0, 1, 0, 1, 0, 0, 0, 0); cycle();
    check("R4", "start with door closed", int'(stateCode), 2);
    idleCycles(FILL_T - 1);
    check("R5", "fill last cycle", int'(stateCode), 2);
    idleCycles(1);
    check("R5", "fill timeout", int'(stateCode), 7);
    check("R9", "flag in fault", int'(faultFlag), 1);
    idleCycles(1);
    check("R8", "fault to armed", int'(stateCode), 1);
    check("R9", "flag held in armed", int'(faultFlag), 1);
    setIn(0, 1, 0, 1, 0, 0, 0, 0); cycle();
    check("R9", "flag cleared on resume", int'(faultFlag), 0);

    // R5 strobes advance; R6 wash length; R8 motor failure in rinse
    setIn(0, 0, 0, 1, 0, 0, 1, 0); cycle();
    check("R5", "level strobe", int'(stateCode), 3);
    setIn(0, 0, 0, 1, 0, 0, 0, 1); cycle();
    check("R5", "heat strobe", int'(stateCode), 4);
    idleCycles(WASH_T - 1);
    check("R6", "wash last cycle", int'(stateCode), 4);
    idleCycles(1);
    check("R6", "wash to rinse", int'(stateCode), 5);
    check("R10", "valve in rinse", int'(waterValve), 1);
    setIn(0, 0, 0, 1, 1, 0, 0, 0); cycle();
    check("R8", "motor fail", int'(stateCode), 7);
    idleCycles(1);
    check("R8", "back to armed", int'(stateCode), 1);

    // R6 full run to idle
    setIn(0, 1, 0, 1, 0, 0, 0, 0); cycle();
    setIn(0, 0, 0, 1, 0, 0, 1, 0); cycle();
    setIn(0, 0, 0, 1, 0, 0, 0, 1); cycle();
    idleCycles(WASH_T);
    check("R6", "rinse entry", int'(stateCode), 5);
    idleCycles(RINSE_T);
    check("R6", "spin entry", int'(stateCode), 6);
    check("R10", "spin motor", int'(motorSpin), 1);
    idleCycles(SPIN_T);
    check("R6", "spin done to idle", int'(stateCode), 0);

    // R7 cancel in heat forfeits coin
    setIn(1, 0, 0, 1, 0, 0, 0, 0); cycle();
    setIn(0, 1, 0, 1, 0, 0, 0, 0); cycle();
    setIn(0, 0, 0, 1, 0, 0, 1, 0); cycle();
    setIn(0, 0, 1, 1, 1, 0, 0, 0); cycle();
    check("R7", "cancel in heat", int'(stateCode), 0);
    check("R7", "no refund", int'(coinReturn), 0);

    // Random phase, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      setIn($urandom_range(0, 99) < 30, $urandom_range(0, 99) < 40,
            $urandom_range(0, 99) < 2,  $urandom_range(0, 99) < 80,
            $urandom_range(0, 199) < 1, $urandom_range(0, 199) < 1,
            $urandom_range(0, 99) < 20, $urandom_range(0, 99) < 25);
      cycle();
    end

    finishRun();
  end

endmodule